// File: doc/BRIEF.md
# NaN Classification and Quieting Unit

This block inspects one 32-bit single-precision word and reports whether it encodes a NaN. When it does, the block also reports whether that NaN is signaling. A single mode input selects how the top fraction bit is read. With the mode set, the newer convention applies and a clear top fraction bit marks a signaling NaN. With the mode clear, the legacy convention applies and a set top fraction bit marks a signaling NaN.

When the caller raises a quieting request and the operand is a signaling NaN, the block returns the quiet form of that NaN and pulses an invalid-operation flag. In every other case the operand comes back unmodified and the flag stays low. Under the legacy convention, clearing the top fraction bit can leave an all-zero fraction, which would encode an infinity. In that case the block sets the next fraction bit down, so the result is still a NaN.

The classification and quieting logic is combinational. A parameter adds an output register, which is on by default and gives one cycle of latency. The flag is not accumulated: it is high only in the cycle that presents the quieted result.

Top module: `nan_quiet_unit`

## Requirements
- R1: `isNan` is 1 exactly when bits 30:23 are all ones and bits 22:0 are not all zero. Infinities (fraction zero) and all finite values give 0.
- R2: With `mode2008`=1, `isSnan` is 1 exactly when the operand is a NaN and bit 22 is 0.
- R3: With `mode2008`=0, `isSnan` is 1 exactly when the operand is a NaN and bit 22 is 1.
- R4: With `mode2008`=1, quieting a signaling NaN sets bit 22 and leaves bits 21:0 unchanged.
- R5: With `mode2008`=0, quieting a signaling NaN clears bit 22. If bits 21:0 are then all zero, it sets bit 21, so the result is always a NaN.
- R6: `invalidFlag` is 1 exactly when `quietReq`=1 and the operand is a signaling NaN under the current mode. It is 0 in the next result if the request is dropped.
- R7: When `quietReq`=0, or when the operand is not a signaling NaN, `quietValue` equals the operand bit for bit and `invalidFlag` is 0.
- R8: Bit 31 (sign) and bits 30:23 (exponent) of `quietValue` always equal those of the operand.
- R9: With the default `REG_OUT`=1, all outputs appear one clock after their inputs. While `rstN`=0, all outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| operand | input | 32 | Single-precision word to classify |
| mode2008 | input | 1 | 1 = newer NaN convention, 0 = legacy convention |
| quietReq | input | 1 | Request to quieten the operand if it is signaling |
| isNan | output | 1 | Operand is a NaN |
| isSnan | output | 1 | Operand is a signaling NaN under the selected convention |
| quietValue | output | 32 | Quieted NaN, or the unmodified operand |
| invalidFlag | output | 1 | Invalid-operation pulse for a performed quieting |

## Verification
The assertions check, on every cycle, the relations between outputs and the registered inputs:
- a signaling report always implies a NaN report;
- the flag only rises for a signaling NaN under a raised request;
- sign and exponent always pass through;
- a quieted result is a quiet NaN under the mode that produced it, with the lower fraction kept in the newer convention.

The bench scenarios cover the rest. They show the exact bit patterns, including the bit-21 repair when the legacy fraction collapses to zero. They show that infinities are not classified as NaNs, that operands are unchanged when no request is raised, and the reset values. They also compare all four outputs against a reference model over random mixtures of NaN, infinity and ordinary patterns in both modes.

// File: rtl/nqu_pkg.sv
package nqu_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic isNan;
    logic isSnan;
    logic setQuiet;    // raise the top fraction bit
    logic clearQuiet;  // drop the top fraction bit
    logic setRepair;   // raise the next fraction bit to stay a NaN
    logic raiseFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/nqu_ctrl.sv
module nqu_ctrl
  import nqu_pkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W,
  localparam int WIDTH    = 1 + EXP_BITS + FRAC_BITS
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             mode2008,
  input  logic             quietReq,
  output ctrlStrobes_t     strobes
);
  logic expAllOnes;
  logic fracNonZero;
  logic topFrac;
  logic lowFracZero;
  logic nanHit;
  logic snanHit;
  logic quietNow;

  always_comb begin
    expAllOnes  = &operand[WIDTH-2:FRAC_BITS];
    fracNonZero = |operand[FRAC_BITS-1:0];
    topFrac     = operand[FRAC_BITS-1];
    lowFracZero = ~|operand[FRAC_BITS-2:0];
    nanHit      = expAllOnes & fracNonZero;
    snanHit     = nanHit & (mode2008 ^ topFrac);
    quietNow    = quietReq & snanHit;

    strobes.isNan      = nanHit;
    strobes.isSnan     = snanHit;
    strobes.raiseFlag  = quietNow;
    strobes.setQuiet   = quietNow & mode2008;
    strobes.clearQuiet = quietNow & ~mode2008;
    strobes.setRepair  = quietNow & ~mode2008 & lowFracZero;
  end
endmodule

// File: rtl/nqu_datapath.sv
module nqu_datapath
  import nqu_pkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W,
  parameter bit REG_OUT   = 1'b1,
  localparam int WIDTH    = 1 + EXP_BITS + FRAC_BITS,
  localparam int Q_POS    = FRAC_BITS - 1,
  localparam int R_POS    = FRAC_BITS - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] operand,
  input  ctrlStrobes_t     strobes,
  output logic             isNan,
  output logic             isSnan,
  output logic [WIDTH-1:0] quietValue,
  output logic             invalidFlag
);
  logic [WIDTH-1:0] nextValue;

  always_comb begin
    nextValue = operand;
    if (strobes.setQuiet)   nextValue[Q_POS] = 1'b1;
    if (strobes.clearQuiet) nextValue[Q_POS] = 1'b0;
    if (strobes.setRepair)  nextValue[R_POS] = 1'b1;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          isNan       <= 1'b0;
          isSnan      <= 1'b0;
          quietValue  <= '0;
          invalidFlag <= 1'b0;
        end else begin
          isNan       <= strobes.isNan;
          isSnan      <= strobes.isSnan;
          quietValue  <= nextValue;
          invalidFlag <= strobes.raiseFlag;
        end
      end
    end else begin : g_comb
      always_comb begin
        isNan       = strobes.isNan;
        isSnan      = strobes.isSnan;
        quietValue  = nextValue;
        invalidFlag = strobes.raiseFlag;
      end
    end
  endgenerate
endmodule

// File: rtl/nan_quiet_unit.sv
module nan_quiet_unit
  import nqu_pkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W,
  parameter bit REG_OUT   = 1'b1,
  localparam int WIDTH    = 1 + EXP_BITS + FRAC_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] operand,
  input  logic             mode2008,
  input  logic             quietReq,
  output logic             isNan,
  output logic             isSnan,
  output logic [WIDTH-1:0] quietValue,
  output logic             invalidFlag
);
  ctrlStrobes_t strobes;

  nqu_ctrl #(.EXP_BITS(EXP_BITS), .FRAC_BITS(FRAC_BITS)) u_ctrl (
    .operand  (operand),
    .mode2008 (mode2008),
    .quietReq (quietReq),
    .strobes  (strobes)
  );

  nqu_datapath #(.EXP_BITS(EXP_BITS), .FRAC_BITS(FRAC_BITS), .REG_OUT(REG_OUT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .operand     (operand),
    .strobes     (strobes),
    .isNan       (isNan),
    .isSnan      (isSnan),
    .quietValue  (quietValue),
    .invalidFlag (invalidFlag)
  );
endmodule

// File: rtl/nqu_checker.sv
module nqu_checker #(
  parameter int EXP_BITS  = 8,
  parameter int FRAC_BITS = 23,
  parameter bit REG_OUT   = 1'b1,
  localparam int WIDTH    = 1 + EXP_BITS + FRAC_BITS
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] operand,
  input logic             mode2008,
  input logic             quietReq,
  input logic             isNan,
  input logic             isSnan,
  input logic [WIDTH-1:0] quietValue,
  input logic             invalidFlag
);
  logic [WIDTH-1:0] opSeen;
  logic             modeSeen;
  logic             reqSeen;
  logic             prevValid;

  always_ff @(posedge clk) begin
    if (!rstN) prevValid <= 1'b0;
    else       prevValid <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_seen_reg
      always_ff @(posedge clk) begin
        opSeen   <= operand;
        modeSeen <= mode2008;
        reqSeen  <= quietReq;
      end
    end else begin : g_seen_comb
      always_comb begin
        opSeen   = operand;
        modeSeen = mode2008;
        reqSeen  = quietReq;
      end
    end
  endgenerate

  // R2 / R3: a signaling report must come with a NaN report
  p_snan_is_nan_r2: assert property (@(posedge clk) disable iff (!rstN)
    prevValid && isSnan |-> isNan);

  // R6: the flag needs a request and a signaling NaN
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    prevValid && invalidFlag |-> (reqSeen && isSnan));

  // R8: sign and exponent pass through
  p_sign_exp_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> quietValue[WIDTH-1:FRAC_BITS] == opSeen[WIDTH-1:FRAC_BITS]);

  // R4: newer convention sets the quiet bit and keeps the lower fraction
  p_quiet_new_r4: assert property (@(posedge clk) disable iff (!rstN)
    prevValid && invalidFlag && modeSeen |->
      (quietValue[FRAC_BITS-1] && quietValue[FRAC_BITS-2:0] == opSeen[FRAC_BITS-2:0]));

  // R5: legacy quieting gives a quiet NaN, never an infinity
  p_quiet_legacy_r5: assert property (@(posedge clk) disable iff (!rstN)
    prevValid && invalidFlag && !modeSeen |->
      (!quietValue[FRAC_BITS-1] && (|quietValue[FRAC_BITS-2:0])));

  // R7: no request means the value is returned untouched
  p_no_req_passthru_r7: assert property (@(posedge clk) disable iff (!rstN)
    prevValid && !reqSeen |-> (quietValue == opSeen && !invalidFlag));
endmodule

bind nan_quiet_unit nqu_checker #(
  .EXP_BITS(EXP_BITS), .FRAC_BITS(FRAC_BITS), .REG_OUT(REG_OUT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .operand     (operand),
  .mode2008    (mode2008),
  .quietReq    (quietReq),
  .isNan       (isNan),
  .isSnan      (isSnan),
  .quietValue  (quietValue),
  .invalidFlag (invalidFlag)
);

// File: tb/nan_quiet_unit_tb.sv
module nan_quiet_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] operand = '0;
  logic        mode2008 = 1'b0;
  logic        quietReq = 1'b0;
  logic        isNan;
  logic        isSnan;
  logic [31:0] quietValue;
  logic        invalidFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nan_quiet_unit u_dut (
    .clk(clk), .rstN(rstN), .operand(operand), .mode2008(mode2008),
    .quietReq(quietReq), .isNan(isNan), .isSnan(isSnan),
    .quietValue(quietValue), .invalidFlag(invalidFlag)
  );

  function automatic bit refNan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit refSnan(input logic [31:0] v, input bit m);
    if (!refNan(v)) return 1'b0;
    return m ? !v[22] : v[22];  // R2 new convention, R3 legacy
  endfunction

  function automatic logic [31:0] refQuiet(input logic [31:0] v, input bit m, input bit r);
    logic [31:0] o;
    o = v;
    if (r && refSnan(v, m)) begin
      if (m) o[22] = 1'b1;           // R4
      else begin                     // R5
        o[22] = 1'b0;
        if (o[21:0] == 0) o[21] = 1'b1;
      end
    end
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge register it, sample at the next falling edge
  task automatic apply(input logic [31:0] v, input bit m, input bit r, input string tag);
    operand  = v;
    mode2008 = m;
    quietReq = r;
    @(negedge clk);
    chk({tag, " R1 isNan"},        {31'b0, isNan},       {31'b0, refNan(v)});
    chk({tag, " R2/R3 isSnan"},    {31'b0, isSnan},      {31'b0, refSnan(v, m)});
    chk({tag, " R4/R5/R8 value"},  quietValue,           refQuiet(v, m, r));
    chk({tag, " R6/R7 flag"},      {31'b0, invalidFlag}, {31'b0, r && refSnan(v, m)});
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    operand = 32'h7F80_0001;
    quietReq = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero during reset
    chk("R9 reset isNan",  {31'b0, isNan},       32'd0);
    chk("R9 reset isSnan", {31'b0, isSnan},      32'd0);
    chk("R9 reset value",  quietValue,           32'd0);
    chk("R9 reset flag",   {31'b0, invalidFlag}, 32'd0);
    rstN = 1'b1;

    // R1: infinities and finites are not NaN
    apply(32'h7F80_0000, 1'b1, 1'b1, "R1 +inf");
    apply(32'hFF80_0000, 1'b0, 1'b1, "R1 -inf");
    apply(32'h3F80_0000, 1'b1, 1'b1, "R1 one");
    // R2, R4: newer convention
    apply(32'h7F80_0001, 1'b1, 1'b1, "R4 snan new");
    apply(32'h7FC0_0001, 1'b1, 1'b1, "R2 qnan new");
    // R3, R5: legacy convention, including the bit-21 repair
    apply(32'hFFC0_0000, 1'b0, 1'b1, "R5 repair");
    apply(32'h7FC0_0005, 1'b0, 1'b1, "R5 clear");
    apply(32'h7F80_0001, 1'b0, 1'b1, "R3 qnan legacy");
    // R7: no request leaves a signaling NaN unchanged
    apply(32'h7FC0_0000, 1'b0, 1'b0, "R7 no req");
    // R6: flag high with request then low once it drops
    apply(32'h7F80_00FF, 1'b1, 1'b1, "R6 pulse on");
    apply(32'h7F80_00FF, 1'b1, 1'b0, "R6 pulse off");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] v;
      int kind;
      v = $urandom;
      kind = $urandom_range(0, 4);
      if (kind <= 2) v[30:23] = 8'hFF;
      if (kind == 1) v[21:0] = 22'd0;
      if (kind == 2) v[22:0] = 23'd0;
      apply(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "rand R8");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule